// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

This block holds two independent 32-bit up-counters, a low half and a high half, clocked together from one clock. Each half has a period register and a two-bit enable field. With the field off, the half is idle. In one-shot mode the half counts up to its period once and then stops. In periodic mode it restarts from zero after reaching the period. A period of all ones turns a half into a free-running counter that wraps at full scale, which is how one half usually serves as a timebase while the other schedules events.

A global control register releases each half from reset and selects the timer mode. Counting only happens in dual unchained mode. An optional compare register on the low half raises the low interrupt when the running counter steps onto the compare value, without stopping the count. This allows event scheduling against a single free-running counter.

Access is through a simple synchronous register port: writes take effect on the clock edge, and reads are combinational from the address. Each half drives a one-cycle interrupt pulse.

Top module: `dual_timer`

## Requirements
- R1: Register map, byte offsets: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, control 0x20, global control 0x24, compare 0x28. Any other offset reads as zero, and writes to it change no register.
- R2: Global control bit 0 releases the low half and bit 1 releases the high half (1 = running, 0 = held in reset). Bits [3:2] select the timer mode. A half held in reset reads zero and ignores writes to its counter. No counter advances unless bits [3:2] equal 01.
- R3: Each enable field is 2 bits: 0 = off, 1 = one-shot, 2 = periodic. The low field sits at control bits [7:6] and the high field at [23:22]. An enabled half advances by exactly one per clock, and an off half holds its count.
- R4: A counter write loads the written value on that edge and takes precedence over counting. A counter read returns the live count.
- R5: In periodic mode a counter that equals its period returns to zero on the next clock. With a period of 0xFFFFFFFF the count runs 0xFFFFFFFE, 0xFFFFFFFF, 0, 1.
- R6: In one-shot mode the counter stops at the period value. Its enable field reads back as 0 from the edge on which the counter reaches the period.
- R7: A half's interrupt is high for exactly the one cycle after the edge on which its counter steps onto the period value. Software loads and the return to zero raise no interrupt.
- R8: The low interrupt also pulses for one cycle when the low counter steps onto the compare value, and counting continues past it.
- R9: A control write that changes one half's field leaves the other half counting in its own mode, with no lost or extra count.
- R10: After reset, counters, control, global control and compare read zero, both periods read 0xFFFFFFFF, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| irq_lo | output | 1 | Low half interrupt pulse (period or compare match) |
| irq_hi | output | 1 | High half interrupt pulse (period match) |

## Verification
A software write to a counter can land on the same edge on which the counter would have stepped onto its period. The bench waits until the low counter sits one step below its period, then issues the write on exactly that edge. It judges the outcome by reading the written value back, seeing no interrupt pulse, and then seeing counting resume from the written value on the next edge. The second contention is a control write that disables one half while the other runs, judged by comparing the running half's count against a cycle counter kept in the bench.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int         DW      = 32,
  parameter int         AW      = 8,
  parameter bit         HAS_CMP = 1'b1,
  parameter logic [7:0] CMP_OFS = 8'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);

  localparam logic [AW-1:0] A_CNT_LO = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT_HI = AW'(8'h14);
  localparam logic [AW-1:0] A_PRD_LO = AW'(8'h18);
  localparam logic [AW-1:0] A_PRD_HI = AW'(8'h1C);
  localparam logic [AW-1:0] A_CTL    = AW'(8'h20);
  localparam logic [AW-1:0] A_GCR    = AW'(8'h24);
  localparam logic [AW-1:0] A_CMP    = AW'(CMP_OFS);
  localparam int            SH_LO    = 6;
  localparam int            SH_HI    = 22;
  localparam logic [1:0]    EN_OFF   = 2'd0;
  localparam logic [1:0]    EN_ONE   = 2'd1;
  localparam logic [1:0]    EN_PER   = 2'd2;
  localparam logic [1:0]    TM_DUAL  = 2'b01;

  logic [1:0]    rel;
  logic [1:0]    tmode;
  logic [DW-1:0] cmp_val;
  logic [DW-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi;
  logic [1:0]    mode_lo, mode_hi;

  wire gcr_we = bus_we && (bus_addr == A_GCR);
  wire ctl_we = bus_we && (bus_addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      {tmode, rel} <= 4'd0;
    else if (gcr_we) {tmode, rel} <= bus_wdata[3:0];

  generate
    if (HAS_CMP) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                             cmp_val <= '0;
        else if (bus_we && bus_addr == A_CMP)   cmp_val <= bus_wdata;
    end else begin : g_nocmp
      assign cmp_val = '0;
    end
  endgenerate

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [AW-1:0] A_C = (h == 0) ? A_CNT_LO : A_CNT_HI;
    localparam logic [AW-1:0] A_P = (h == 0) ? A_PRD_LO : A_PRD_HI;
    localparam int            SH  = (h == 0) ? SH_LO : SH_HI;

    logic [DW-1:0] cnt, prd, nxt;
    logic [1:0]    mode;
    logic          irq_q, active, at_prd, step, wrap, land, cmp_hit, cwr, stop;

    assign cwr     = bus_we && (bus_addr == A_C);
    assign active  = rel[h] && (tmode == TM_DUAL) && (mode == EN_ONE || mode == EN_PER);
    assign at_prd  = (cnt == prd);
    assign nxt     = cnt + DW'(1);
    assign step    = active && !at_prd && !cwr;
    assign wrap    = active && at_prd && (mode == EN_PER) && !cwr;
    assign land    = step && (nxt == prd);
    assign cmp_hit = (h == 0) && HAS_CMP && step && (nxt == cmp_val);
    assign stop    = active && (mode == EN_ONE) && !cwr && (land || at_prd);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt <= '0;
      else if (!rel[h]) cnt <= '0;
      else if (cwr)     cnt <= bus_wdata;
      else if (wrap)    cnt <= '0;
      else if (step)    cnt <= nxt;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            prd <= '1;
      else if (bus_we && bus_addr == A_P)    prd <= bus_wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      mode <= EN_OFF;
      else if (ctl_we) mode <= bus_wdata[SH +: 2];
      else if (stop)   mode <= EN_OFF;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= land || cmp_hit;
  end

  assign cnt_lo  = g_half[0].cnt;
  assign cnt_hi  = g_half[1].cnt;
  assign prd_lo  = g_half[0].prd;
  assign prd_hi  = g_half[1].prd;
  assign mode_lo = g_half[0].mode;
  assign mode_hi = g_half[1].mode;
  assign irq_lo  = g_half[0].irq_q;
  assign irq_hi  = g_half[1].irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_lo;
      A_CNT_HI: bus_rdata = cnt_hi;
      A_PRD_LO: bus_rdata = prd_lo;
      A_PRD_HI: bus_rdata = prd_hi;
      A_CTL: begin
        bus_rdata[SH_LO +: 2] = mode_lo;
        bus_rdata[SH_HI +: 2] = mode_hi;
      end
      A_GCR:    bus_rdata[3:0] = {tmode, rel};
      default:  ;
    endcase
    if (HAS_CMP && bus_addr == A_CMP) bus_rdata = cmp_val;
  end

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_hi,
  input logic [1:0]    rel,
  input logic [1:0]    tmode,
  input logic [DW-1:0] cnt_lo,
  input logic [DW-1:0] cnt_hi,
  input logic [DW-1:0] prd_hi,
  input logic [1:0]    mode_hi
);

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0)) |-> (bus_rdata == '0));

  // R2
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rel[0] |=> (cnt_lo == '0));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && rel[1] && tmode == 2'b01 && mode_hi == 2'd2 && cnt_hi != prd_hi)
    |=> (cnt_hi == $past(cnt_hi) + DW'(1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi == 2'd0 && !bus_we) |=> $stable(cnt_hi));

  // R5
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && rel[1] && tmode == 2'b01 && mode_hi == 2'd2 && cnt_hi == prd_hi)
    |=> (cnt_hi == '0));

  // R7
  irq_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (cnt_hi == $past(prd_hi)));

endmodule

bind dual_timer dual_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_hi   (irq_hi),
  .rel      (rel),
  .tmode    (tmode),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .prd_hi   (prd_hi),
  .mode_hi  (mode_hi)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;

  localparam logic [7:0] A_CNT_LO = 8'h10, A_CNT_HI = 8'h14, A_PRD_LO = 8'h18,
                         A_PRD_HI = 8'h1C, A_CTL = 8'h20, A_GCR = 8'h24, A_CMP = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  dual_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT_LO, v); chk("R10 cnt_lo", v, 32'h0);
    rd(A_CNT_HI, v); chk("R10 cnt_hi", v, 32'h0);
    rd(A_PRD_LO, v); chk("R10 prd_lo", v, 32'hFFFF_FFFF);
    rd(A_PRD_HI, v); chk("R10 prd_hi", v, 32'hFFFF_FFFF);
    rd(A_CTL, v);    chk("R10 ctl", v, 32'h0);
    rd(A_GCR, v);    chk("R10 gcr", v, 32'h0);
    rd(A_CMP, v);    chk("R10 cmp", v, 32'h0);
    chk("R10 irq_lo", {31'b0, irq_lo}, 32'h0);
    chk("R10 irq_hi", {31'b0, irq_hi}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, v);    chk("R1 read 0x00", v, 32'h0);
    rd(8'h2C, v);    chk("R1 read 0x2C", v, 32'h0);
    rd(A_CTL, v);    chk("R1 ctl untouched", v, 32'h0);
    rd(A_GCR, v);    chk("R1 gcr untouched", v, 32'h0);
    rd(A_CNT_LO, v); chk("R1 cnt_lo untouched", v, 32'h0);
    rd(A_PRD_HI, v); chk("R1 prd_hi untouched", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_gcr();
    logic [31:0] v;
    wr(A_GCR, 32'h4);
    wr(A_CNT_LO, 32'd5);
    rd(A_CNT_LO, v); chk("R2 write ignored in reset", v, 32'h0);
    wr(A_CTL, 32'd2 << 6);
    repeat (4) @(negedge clk);
    rd(A_CNT_LO, v); chk("R2 no count in reset", v, 32'h0);
    wr(A_GCR, 32'h3);
    wr(A_CNT_LO, 32'd7);
    repeat (4) @(negedge clk);
    rd(A_CNT_LO, v); chk("R2 no count unless mode 01", v, 32'd7);
    rd(A_GCR, v);    chk("R2 gcr readback", v, 32'h3);
    wr(A_CTL, 32'h0);
    wr(A_GCR, 32'h7);
  endtask

  task automatic t_count();
    logic [31:0] v;
    int unsigned c0;
    wr(A_CTL, 32'h0);
    wr(A_CNT_LO, 32'd100);
    wr(A_CNT_HI, 32'd0);
    wr(A_CTL, 32'd2 << 6);
    c0 = cyc;
    rd(A_CNT_LO, v); chk("R4 live count", v, 32'd100 + (cyc - c0));
    repeat (9) @(negedge clk);
    rd(A_CNT_LO, v); chk("R3 one per clock", v, 32'd100 + (cyc - c0));
    rd(A_CTL, v);    chk("R3 ctl readback", v, 32'h80);
    rd(A_CNT_HI, v); chk("R3 off half holds", v, 32'h0);
  endtask

  task automatic t_periodic();
    int unsigned c0, k;
    int pulses = 0;
    wr(A_CTL, 32'h0);
    wr(A_CNT_LO, 32'h0);
    wr(A_PRD_LO, 32'd5);
    wr(A_CTL, 32'd2 << 6);
    c0 = cyc;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      bus_addr = A_CNT_LO;
      #1;
      k = cyc - c0;
      chk("R5 periodic count", bus_rdata, k % 6);
      chk("R7 periodic irq", {31'b0, irq_lo}, {31'b0, (k % 6) == 5});
      if (irq_lo) pulses++;
    end
    chk("R7 pulse count", pulses, 2);
  endtask

  task automatic t_fullscale();
    int unsigned c0, k;
    wr(A_CTL, 32'h0);
    wr(A_CNT_HI, 32'hFFFF_FFFD);
    wr(A_CTL, 32'd2 << 22);
    c0 = cyc;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_addr = A_CNT_HI;
      #1;
      k = cyc - c0;
      chk("R5 full-scale wrap", bus_rdata, 32'hFFFF_FFFD + k);
      chk("R7 full-scale irq", {31'b0, irq_hi}, {31'b0, k == 2});
    end
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int unsigned c0, k;
    wr(A_CTL, 32'h0);
    wr(A_CNT_LO, 32'd10);
    wr(A_PRD_LO, 32'd13);
    wr(A_CTL, 32'd1 << 6);
    c0 = cyc;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      bus_addr = A_CNT_LO;
      #1;
      k = cyc - c0;
      chk("R6 one-shot count", bus_rdata, (k >= 3) ? 32'd13 : 32'd10 + k);
      chk("R7 one-shot irq", {31'b0, irq_lo}, {31'b0, k == 3});
      bus_addr = A_CTL;
      #1;
      chk("R6 field clears", bus_rdata, (k >= 3) ? 32'h0 : 32'h40);
    end
    rd(A_CNT_LO, v); chk("R6 stays at period", v, 32'd13);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    int unsigned c0, k;
    wr(A_CTL, 32'h0);
    wr(A_PRD_LO, 32'hFFFF_FFFF);
    wr(A_CMP, 32'd7);
    wr(A_CNT_LO, 32'h0);
    wr(A_CTL, 32'd2 << 6);
    c0 = cyc;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      bus_addr = A_CNT_LO;
      #1;
      k = cyc - c0;
      chk("R8 keeps counting", bus_rdata, k);
      chk("R8 compare irq", {31'b0, irq_lo}, {31'b0, k == 7});
    end
    rd(A_CMP, v); chk("R8 cmp readback", v, 32'd7);
  endtask

  task automatic t_indep();
    logic [31:0] v, held;
    int unsigned c0;
    wr(A_CTL, 32'h0);
    wr(A_CNT_HI, 32'h0);
    wr(A_CTL, 32'd2 << 22);
    c0 = cyc;
    wr(A_CNT_LO, 32'h0);
    wr(A_PRD_LO, 32'd3);
    wr(A_CTL, (32'd2 << 22) | (32'd1 << 6));
    rd(A_CNT_HI, v); chk("R9 hi unaffected by ctl write", v, cyc - c0);
    repeat (5) @(negedge clk);
    rd(A_CTL, v);    chk("R9 hi field kept, lo cleared", v, 32'd2 << 22);
    rd(A_CNT_LO, v); chk("R9 lo one-shot done", v, 32'd3);
    rd(A_CNT_HI, v); chk("R9 hi still counting", v, cyc - c0);
    wr(A_CTL, 32'h0);
    rd(A_CNT_HI, held);
    repeat (3) @(negedge clk);
    rd(A_CNT_HI, v); chk("R3 disabled half holds", v, held);
  endtask

  task automatic t_collision();
    int unsigned c0;
    wr(A_CTL, 32'h0);
    wr(A_CMP, 32'h0);
    wr(A_CNT_LO, 32'h0);
    wr(A_PRD_LO, 32'd20);
    wr(A_CTL, 32'd2 << 6);
    c0 = cyc;
    while (cyc - c0 < 19) @(negedge clk);
    bus_addr = A_CNT_LO; bus_wdata = 32'h50; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    chk("R4 write wins over step", bus_rdata, 32'h50);
    chk("R7 no irq on load", {31'b0, irq_lo}, 32'h0);
    @(negedge clk);
    #1;
    chk("R4 counting resumes", bus_rdata, 32'h51);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unmapped();
    t_gcr();
    t_count();
    t_periodic();
    t_fullscale();
    t_oneshot();
    t_compare();
    t_indep();
    t_collision();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule